// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an 8-bit counter with two compare channels (A and B), each driving a waveform pin through a 2-bit action code. A 3-bit mode field in the control register selects one of four behaviours: free counting, clear-on-compare, fast PWM or phase-correct PWM. In both PWM styles the ceiling (TOP) is either fixed at the all-ones value or taken from channel A's compare value. The counter advances on every clock.

Compare values are written into shadow registers. Outside the PWM modes a write reaches the active compare value at once. Inside them the shadow is copied at the TOP event, so a period is never cut short. An overflow flag and one match flag per channel are kept sticky until software clears them. A force strobe applies a channel's action to its pin without a real match. It only works outside the PWM modes.

Software reaches the block through a single write/read port. Read data is registered.

Top module: `pwm8_timer`

## Requirements
- R1: The mode is held in control register (address 0) bits [2:0]. The counting sequences per mode are as follows.
  - Mode 0 counts up and wraps from 0xFF to 0.
  - Modes 3 and 7 count up and wrap from TOP to 0.
  - Modes 1 and 5 count up to TOP and then down to 0. They reverse without repeating either endpoint.
  - In modes 4 and 6 the counter, direction, pins and pin enables hold their values, and no flag is set.
- R2: TOP is 0xFF in modes 0, 1 and 3, and is the active channel A compare value in modes 2, 5 and 7.
- R3: A write to a compare register (A at address 2, B at address 3) always updates its shadow. Outside modes 1, 3, 5 and 7 the write also updates the active value in the same clock. In those four modes the shadow is copied to the active value only at the TOP event: the wrap in fast PWM, or the turnaround at the top in phase-correct PWM.
- R4: The overflow flag (flag register bit 0) is set at the following points:
  - in modes 0, 2 and 3, on the clock after the count equals 0xFF;
  - in mode 7, on the clock after it equals TOP;
  - in modes 1 and 5, on the clock after it reaches 0 while counting down.
- R5: A channel's match flag (flag register bit 1 for A, bit 2 for B) is set on the clock after the count equals that channel's active compare value. This happens in every non-reserved mode.
- R6: In mode 2 the counter becomes 0 on the clock after it equals the channel A compare value.
- R7: The control register holds the action codes, channel A in bits [4:3] and channel B in bits [6:5]. In modes 0 and 2 the codes act as follows.
  - Code 00 leaves the pin alone and drops its enable.
  - Code 01 toggles the pin on a match.
  - Code 10 clears the pin on a match.
  - Code 11 sets the pin on a match.
- R8: In fast PWM, code 10 clears the pin on a match and sets it at the wrap. Code 11 does the inverse. When both events fall on the same clock, the wrap action wins. Codes 00 and 01 leave the pin alone and drop its enable.
- R9: In phase-correct PWM, code 10 clears the pin on a match while counting up and sets it on a match while counting down. Code 11 does the inverse. Codes 00 and 01 leave the pin alone and drop its enable.
- R10: Writing 1 to bit 0 (A) or bit 1 (B) of the strobe register (address 1) applies that channel's current action code to its pin on the next clock, but only in modes 0 and 2. The strobe sets no flag and never clears the counter. In all other modes it has no effect. A strobe that coincides with a genuine match applies the action once.
- R11: The strobe register always reads as 0.
- R12: Writing 1 to a bit of the flag register (address 5) clears that flag. A set event in the same clock takes priority over the clear.
- R13: Read data is the selected register's value before the current clock edge and appears one clock after the address:
  - address 0 gives the control register, with bit 7 read as 0;
  - addresses 2 and 3 give the shadow compare values;
  - address 4 gives the count;
  - address 5 gives the flags;
  - every other address reads as 0.
- R14: After reset every register, pin, enable, flag and the read data are 0. The mode is therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable for the register port |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky channel A match flag |
| cmpb_flag | output | 1 | Sticky channel B match flag |
| wave_a | output | 1 | Channel A waveform pin |
| wave_a_oe | output | 1 | Channel A pin enable |
| wave_b | output | 1 | Channel B waveform pin |
| wave_b_oe | output | 1 | Channel B pin enable |

## Verification
Several functions can collide in one clock:
- a force strobe and a genuine compare match on the same channel;
- a flag-clear write and the overflow that sets that flag;
- a compare write and the TOP reload in PWM mode.

The bench produces each collision by waiting, in its own reference model, until the count sits at the compare value, 0xFF or TOP, and issuing the write during that very cycle. For a toggle action the pin must change exactly once and the match flag must still rise. The flag must stay set when the clear meets a set event. The reloaded compare value must be the old shadow, not the value written in that clock.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  typedef enum logic [2:0] {
    MODE_FREE      = 3'd0,
    MODE_PC_FULL   = 3'd1,
    MODE_CTC       = 3'd2,
    MODE_FAST_FULL = 3'd3,
    MODE_RSV_A     = 3'd4,
    MODE_PC_CMP    = 3'd5,
    MODE_RSV_B     = 3'd6,
    MODE_FAST_CMP  = 3'd7
  } mode_e;

  localparam int NCH       = 2;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STB  = 1;
  localparam int ADDR_CMP0 = 2;
  localparam int ADDR_CNT  = 4;
  localparam int ADDR_FLG  = 5;
  localparam int CTRL_W    = 3 + 2 * NCH;

  function automatic logic is_rsv(mode_e m);
    return (m == MODE_RSV_A) || (m == MODE_RSV_B);
  endfunction

  function automatic logic is_fast(mode_e m);
    return (m == MODE_FAST_FULL) || (m == MODE_FAST_CMP);
  endfunction

  function automatic logic is_phase(mode_e m);
    return (m == MODE_PC_FULL) || (m == MODE_PC_CMP);
  endfunction

  function automatic logic is_pwm(mode_e m);
    return is_fast(m) || is_phase(m);
  endfunction

  function automatic logic is_nonpwm(mode_e m);
    return (m == MODE_FREE) || (m == MODE_CTC);
  endfunction

  function automatic logic top_from_cmp(mode_e m);
    return (m == MODE_CTC) || (m == MODE_PC_CMP) || (m == MODE_FAST_CMP);
  endfunction

endpackage

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  logic [W-1:0] cmp_a,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         wrap_evt,
  output logic         reload_evt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] top;
  logic [W-1:0] cnt_d;
  logic         dir_d;

  always_comb begin
    top        = top_from_cmp(mode) ? cmp_a : MAXV;
    wrap_evt   = is_fast(mode) && (cnt == top);
    reload_evt = wrap_evt || (is_phase(mode) && !dir_down && (cnt >= top));
    ovf_evt    = 1'b0;
    case (mode)
      MODE_FREE, MODE_CTC, MODE_FAST_FULL: ovf_evt = (cnt == MAXV);
      MODE_FAST_CMP:                       ovf_evt = (cnt == top);
      MODE_PC_FULL, MODE_PC_CMP:           ovf_evt = dir_down && (cnt == ZERO);
      default:                             ovf_evt = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d = cnt;
    dir_d = 1'b0;
    case (mode)
      MODE_FREE: cnt_d = cnt + ONE;
      MODE_CTC:  cnt_d = (cnt == cmp_a) ? ZERO : cnt + ONE;
      MODE_FAST_FULL, MODE_FAST_CMP: cnt_d = wrap_evt ? ZERO : cnt + ONE;
      MODE_PC_FULL, MODE_PC_CMP: begin
        if (!dir_down) begin
          if (cnt >= top) begin
            dir_d = 1'b1;
            cnt_d = (cnt == ZERO) ? ZERO : cnt - ONE;
          end else begin
            cnt_d = cnt + ONE;
          end
        end else if (cnt == ZERO) begin
          dir_d = 1'b0;
          cnt_d = (top == ZERO) ? ZERO : ONE;
        end else begin
          dir_d = 1'b1;
          cnt_d = cnt - ONE;
        end
      end
      default: begin
        cnt_d = cnt;
        dir_d = dir_down;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= ZERO;
      dir_down <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      dir_down <= dir_d;
    end
  end

  // R1: reserved modes freeze the count
  p_rsv_hold_r1: assert property (@(posedge clk) disable iff (rst)
    is_rsv(mode) |=> (cnt == $past(cnt)));

  // R1: phase-correct turnaround at the ceiling
  p_phase_turn_r1: assert property (@(posedge clk) disable iff (rst)
    (is_phase(mode) && !dir_down && (cnt >= top) && (top != ZERO)) |=> dir_down);

  // R2: fast PWM wraps at its ceiling
  p_fast_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (is_fast(mode) && (cnt == top)) |=> (cnt == ZERO));

  // R6: clear-on-compare returns to zero
  p_ctc_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_CTC) && (cnt == cmp_a)) |=> (cnt == ZERO));

endmodule

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [W-1:0]           wdata,
  input  logic [W-1:0]           cnt,
  input  logic                   reload_evt,
  input  logic                   ovf_evt,
  input  logic [NCH-1:0]         match_evt,
  output mode_e                  mode,
  output logic [NCH-1:0][1:0]    act,
  output logic [NCH-1:0][W-1:0]  ocr,
  output logic [NCH-1:0]         force_req,
  output logic                   flag_ovf,
  output logic [NCH-1:0]         flag_cmp,
  output logic [W-1:0]           rdata
);
  logic [CTRL_W-1:0]       ctrl_q;
  logic [NCH-1:0][W-1:0]   shadow_q;
  logic [W-1:0]            rd_d;
  logic                    wr_ctrl, wr_stb, wr_flg;
  logic [NCH-1:0]          wr_cmp;

  always_comb begin
    mode    = mode_e'(ctrl_q[2:0]);
    wr_ctrl = we && (addr == AW'(ADDR_CTRL));
    wr_stb  = we && (addr == AW'(ADDR_STB));
    wr_flg  = we && (addr == AW'(ADDR_FLG));
    for (int c = 0; c < NCH; c++) begin
      act[c]       = ctrl_q[3 + 2*c +: 2];
      wr_cmp[c]    = we && (addr == AW'(ADDR_CMP0 + c));
      force_req[c] = wr_stb && wdata[c];
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr == AW'(ADDR_CTRL)) rd_d = W'(ctrl_q);
    if (addr == AW'(ADDR_CNT))  rd_d = cnt;
    if (addr == AW'(ADDR_FLG))  rd_d = W'({flag_cmp, flag_ovf});
    for (int c = 0; c < NCH; c++) begin
      if (addr == AW'(ADDR_CMP0 + c)) rd_d = shadow_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
      ocr      <= '0;
      flag_ovf <= 1'b0;
      flag_cmp <= '0;
      rdata    <= '0;
    end else begin
      rdata <= rd_d;
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (is_pwm(mode) && reload_evt) ocr[c] <= shadow_q[c];
        if (wr_cmp[c]) begin
          shadow_q[c] <= wdata;
          if (!is_pwm(mode)) ocr[c] <= wdata;
        end
        flag_cmp[c] <= (flag_cmp[c] && !(wr_flg && wdata[c+1])) || match_evt[c];
      end
      flag_ovf <= (flag_ovf && !(wr_flg && wdata[0])) || ovf_evt;
    end
  end

  // R11: strobe address always reads zero
  p_strobe_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (addr == AW'(ADDR_STB)) |=> (rdata == '0));

  // R3: in PWM modes the active compare only moves at the TOP event
  p_buf_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (is_pwm(mode) && !reload_evt) |=> $stable(ocr));

  // R4: overflow event always leaves the flag set (set beats clear)
  p_ovf_set_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flag_ovf);

  // R5: match event on channel A leaves its flag set
  p_cmp_set_r5: assert property (@(posedge clk) disable iff (rst)
    match_evt[0] |=> flag_cmp[0]);

endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  logic [1:0]   act,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         dir_down,
  input  logic         wrap_evt,
  input  logic         force_req,
  output logic         match_evt,
  output logic         pin,
  output logic         pin_oe
);
  logic pin_d, oe_d, frc;

  always_comb begin
    match_evt = !is_rsv(mode) && (cnt == cmp);
    frc       = force_req && is_nonpwm(mode);
    pin_d     = pin;
    oe_d      = pin_oe;
    if (!is_rsv(mode)) begin
      if (is_nonpwm(mode)) begin
        oe_d = (act != 2'b00);
        if (match_evt || frc) begin
          case (act)
            2'b01:   pin_d = ~pin;
            2'b10:   pin_d = 1'b0;
            2'b11:   pin_d = 1'b1;
            default: pin_d = pin;
          endcase
        end
      end else begin
        oe_d = act[1];
        if (act[1]) begin
          if (is_fast(mode)) begin
            if (wrap_evt)       pin_d = ~act[0];
            else if (match_evt) pin_d = act[0];
          end else if (match_evt) begin
            pin_d = dir_down ? ~act[0] : act[0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin    <= 1'b0;
      pin_oe <= 1'b0;
    end else begin
      pin    <= pin_d;
      pin_oe <= oe_d;
    end
  end

  // R1: reserved modes leave the pin untouched
  p_rsv_pin_r1: assert property (@(posedge clk) disable iff (rst)
    is_rsv(mode) |=> $stable(pin));

  // R10: a strobe in a PWM mode with no other event changes nothing
  p_force_pwm_r10: assert property (@(posedge clk) disable iff (rst)
    (force_req && is_pwm(mode) && !match_evt && !wrap_evt) |=> $stable(pin));

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          ovf_flag,
  output logic          cmpa_flag,
  output logic          cmpb_flag,
  output logic          wave_a,
  output logic          wave_a_oe,
  output logic          wave_b,
  output logic          wave_b_oe
);
  mode_e                  mode;
  logic [NCH-1:0][1:0]    act;
  logic [NCH-1:0][W-1:0]  ocr;
  logic [NCH-1:0]         force_req;
  logic [NCH-1:0]         match_evt;
  logic [NCH-1:0]         flag_cmp;
  logic [NCH-1:0]         pin, pin_oe;
  logic [W-1:0]           cnt;
  logic                   dir_down, wrap_evt, reload_evt, ovf_evt;

  pwm8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .mode(mode), .cmp_a(ocr[0]),
    .cnt(cnt), .dir_down(dir_down), .wrap_evt(wrap_evt),
    .reload_evt(reload_evt), .ovf_evt(ovf_evt)
  );

  pwm8_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .reload_evt(reload_evt), .ovf_evt(ovf_evt),
    .match_evt(match_evt), .mode(mode), .act(act), .ocr(ocr),
    .force_req(force_req), .flag_ovf(ovf_flag), .flag_cmp(flag_cmp),
    .rdata(bus_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm8_wave #(.W(W)) u_wave (
      .clk(clk), .rst(rst), .mode(mode), .act(act[c]), .cnt(cnt),
      .cmp(ocr[c]), .dir_down(dir_down), .wrap_evt(wrap_evt),
      .force_req(force_req[c]), .match_evt(match_evt[c]),
      .pin(pin[c]), .pin_oe(pin_oe[c])
    );
  end

  assign cmpa_flag = flag_cmp[0];
  assign cmpb_flag = flag_cmp[1];
  assign wave_a    = pin[0];
  assign wave_b    = pin[1];
  assign wave_a_oe = pin_oe[0];
  assign wave_b_oe = pin_oe[1];

endmodule

// File: tb/pwm8_timer_tb.sv
module pwm8_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic ovf_flag, cmpa_flag, cmpb_flag, wave_a, wave_a_oe, wave_b, wave_b_oe;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_ctrl, m_cnt, m_dir, m_fo, m_rd;
  int m_sh[2], m_ocr[2], m_fc[2], m_pin[2], m_oe[2];

  always #5 clk = ~clk;

  pwm8_timer dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag),
    .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag), .wave_a(wave_a),
    .wave_a_oe(wave_a_oe), .wave_b(wave_b), .wave_b_oe(wave_b_oe)
  );

  task automatic model_step();
    int md, top, nc, nd, rd, act, clr;
    bit pwm, nonpwm, fast, phase, rsv, wrap, reload, ovf;
    bit mt[2];
    bit fr[2];
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_dir = 0; m_fo = 0; m_rd = 0;
      for (int c = 0; c < 2; c++) begin
        m_sh[c] = 0; m_ocr[c] = 0; m_fc[c] = 0; m_pin[c] = 0; m_oe[c] = 0;
      end
      return;
    end
    md     = m_ctrl & 7;
    fast   = (md == 3) || (md == 7);
    phase  = (md == 1) || (md == 5);
    pwm    = fast || phase;
    nonpwm = (md == 0) || (md == 2);
    rsv    = (md == 4) || (md == 6);
    top    = (md == 2 || md == 5 || md == 7) ? m_ocr[0] : 255;
    case (bus_addr)
      3'd0: rd = m_ctrl;
      3'd2: rd = m_sh[0];
      3'd3: rd = m_sh[1];
      3'd4: rd = m_cnt;
      3'd5: rd = m_fo + 2 * m_fc[0] + 4 * m_fc[1];
      default: rd = 0;
    endcase
    for (int c = 0; c < 2; c++) begin
      mt[c] = !rsv && (m_cnt == m_ocr[c]);
      fr[c] = bus_we && (bus_addr == 3'd1) && bus_wdata[c] && nonpwm;
    end
    wrap   = fast && (m_cnt == top);
    reload = wrap || (phase && m_dir == 0 && m_cnt >= top);
    ovf    = ((md == 0 || md == 2 || md == 3) && m_cnt == 255) ||
             (md == 7 && m_cnt == top) || (phase && m_dir == 1 && m_cnt == 0);
    nc = m_cnt; nd = 0;
    if (md == 0) nc = (m_cnt + 1) % 256;
    else if (md == 2) nc = (m_cnt == m_ocr[0]) ? 0 : (m_cnt + 1) % 256;
    else if (fast) nc = (m_cnt == top) ? 0 : (m_cnt + 1) % 256;
    else if (phase) begin
      if (m_dir == 0) begin
        if (m_cnt >= top) begin nd = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
        else nc = m_cnt + 1;
      end else if (m_cnt == 0) begin nd = 0; nc = (top == 0) ? 0 : 1; end
      else begin nd = 1; nc = m_cnt - 1; end
    end else begin nc = m_cnt; nd = m_dir; end
    for (int c = 0; c < 2; c++) begin
      act = (m_ctrl >> (3 + 2 * c)) & 3;
      if (nonpwm) begin
        m_oe[c] = (act != 0);
        if (mt[c] || fr[c]) begin
          if (act == 1) m_pin[c] = 1 - m_pin[c];
          else if (act == 2) m_pin[c] = 0;
          else if (act == 3) m_pin[c] = 1;
        end
      end else if (pwm) begin
        m_oe[c] = (act >= 2);
        if (act >= 2) begin
          if (fast) begin
            if (wrap) m_pin[c] = (act == 2);
            else if (mt[c]) m_pin[c] = (act == 3);
          end else if (mt[c]) begin
            m_pin[c] = (m_dir == 0) ? (act == 3) : (act == 2);
          end
        end
      end
    end
    clr = (bus_we && bus_addr == 3'd5) ? int'(bus_wdata) : 0;
    m_fo = ((m_fo == 1) && !clr[0]) || ovf;
    for (int c = 0; c < 2; c++) begin
      m_fc[c] = ((m_fc[c] == 1) && !clr[c+1]) || mt[c];
      if (pwm && reload) m_ocr[c] = m_sh[c];
      if (bus_we && bus_addr == 3'(2 + c)) begin
        m_sh[c] = bus_wdata;
        if (!pwm) m_ocr[c] = bus_wdata;
      end
    end
    if (bus_we && bus_addr == 3'd0) m_ctrl = bus_wdata & 127;
    m_cnt = nc; m_dir = nd; m_rd = rd;
  endtask

  always @(posedge clk) model_step();

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7/R8/R9/R10 wave_a", wave_a, m_pin[0]);
      chk("R7/R8/R9/R10 wave_b", wave_b, m_pin[1]);
      chk("R7/R8/R9 wave_a_oe", wave_a_oe, m_oe[0]);
      chk("R7/R8/R9 wave_b_oe", wave_b_oe, m_oe[1]);
      chk("R4/R12 ovf_flag", ovf_flag, m_fo);
      chk("R5/R12 cmpa_flag", cmpa_flag, m_fc[0]);
      chk("R5/R12 cmpb_flag", cmpb_flag, m_fc[1]);
      chk("R13 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input int k);
    while (m_cnt != k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, v;
    repeat (3) @(negedge clk);
    chk("R14 reset rdata", bus_rdata, 0);
    chk("R14 reset wave_a", wave_a, 0);
    chk("R14 reset oe", wave_b_oe, 0);
    chk("R14 reset ovf", ovf_flag, 0);
    rst = 1'b0;

    // R1 R7 free-running with toggle / set actions
    wr(2, 'h10); wr(3, 'h20); wr(0, 0 | (1 << 3) | (3 << 5));
    idle(300);
    wait_cnt(200); bus_addr = 3'd4; idle(1);
    chk("R1 count readback", bus_rdata, 200);
    wr(1, 0); idle(1);
    chk("R11 strobe reads zero", bus_rdata, 0);

    // R10 strobe colliding with a genuine match (toggle once, flag set)
    wr(5, 7);
    wait_cnt('h10); p = wave_a; wr(1, 1);
    chk("R10 toggle once on collision", wave_a, 1 - p);
    chk("R5 flag on collision", cmpa_flag, 1);
    idle(1);
    chk("R10 no second toggle", wave_a, 1 - p);

    // R10 strobe alone: action at strobe time, no flag
    wr(5, 7);
    wait_cnt(100);
    wr(0, 0 | (3 << 3) | (3 << 5)); wr(1, 1);
    chk("R10 force set", wave_a, 1);
    wr(0, 0 | (2 << 3) | (3 << 5)); wr(1, 1);
    chk("R10 force clear", wave_a, 0);
    chk("R10 no flag from force", cmpa_flag, 0);

    // R6 clear-on-compare
    wr(2, 'h30); wr(0, 2 | (1 << 3) | (1 << 5));
    idle(200);
    wait_cnt('h20); wr(1, 1); bus_addr = 3'd4; idle(1);
    chk("R10 force does not clear counter", bus_rdata, 'h21);
    wait_cnt('h30); idle(2);
    chk("R6 counter cleared after match", bus_rdata, 0);

    // R8 R3 fast PWM, fixed ceiling
    wr(2, 'h40); wr(3, 'hC0); wr(0, 3 | (2 << 3) | (3 << 5));
    idle(600);
    wait_cnt('h30); wr(2, 'h80);
    wait_cnt('h60);
    chk("R3 old compare active until wrap", wave_a, 0);
    idle(1); wait_cnt('h60);
    chk("R3 new compare after wrap", wave_a, 1);

    // R2 fast PWM with ceiling from compare A
    wr(2, 'h50); wr(3, 'h20); wr(0, 7 | (0 << 3) | (2 << 5));
    idle(600);
    wait_cnt('h50); bus_addr = 3'd4; idle(2);
    chk("R2 wrap at compare A ceiling", bus_rdata, 0);
    wait_cnt('h10); p = wave_b; wr(1, 2);
    chk("R10 force ignored in PWM", wave_b, p);

    // R9 R4 phase-correct, fixed ceiling
    wr(2, 'h40); wr(3, 'h90); wr(0, 1 | (2 << 3) | (3 << 5));
    idle(1100);
    wait_cnt(200); wr(5, 7); wait_cnt(255); idle(1);
    chk("R4 no overflow at ceiling in phase mode", ovf_flag, 0);
    while (!(m_cnt == 0 && m_dir == 1)) @(negedge clk);
    idle(1);
    chk("R4 overflow at bottom in phase mode", ovf_flag, 1);

    // R9 R2 phase-correct, ceiling from compare A
    wr(2, 'h60); wr(0, 5 | (3 << 3) | (2 << 5));
    idle(1000);

    // R1 reserved mode holds everything
    wr(0, 4 | (1 << 3) | (1 << 5)); bus_addr = 3'd4;
    idle(3); v = bus_rdata; p = wave_a;
    idle(20);
    chk("R1 reserved holds count", bus_rdata, v);
    chk("R1 reserved holds pin", wave_a, p);

    // R12 clear meets set
    wr(0, 0 | (1 << 3) | (1 << 5));
    wait_cnt(255); wr(5, 1);
    chk("R12 set wins over clear", ovf_flag, 1);
    wr(5, 1);
    chk("R12 clear by write", ovf_flag, 0);
    idle(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule